// File: doc/BRIEF.md
# Resampler Configuration Derivation Checker

This block turns a set of polyphase resampler settings into the filter geometry they imply. The settings are: the number of complex multiplies spent per output sample, how many filters share the coefficient memory, how many resampler channels are active, whether the filter is symmetric, whether only one output is produced, and how many clock cycles are available per output. From these the block derives the number of polyphase branches (the delay count) and the total filter length in taps.

It also checks each setting against the hardware limits and raises a separate violation flag for each kind of breach. Control logic pulses `load` with the settings on the inputs. The violation flags appear on the next clock edge. A short sequential divider then works out the delay count, and `done` pulses once the delay count and tap count are valid. The cycle budget comes in as an input, and the rate arithmetic that would produce it is not part of this block.

Top module: `rsmp_cfg_derive`

## Requirements
- R1: The four violation flags are captured on the clock edge that samples `load` high. They keep their values, whatever the inputs do, until the next such edge.
- R2: `ndelay` is the largest power of two that is not above 512 / (nmult × F × 2^nonsym), and `taps` = `ndelay` × `nmult`. F is 1, 2 or 4 for `filt_sel` codes 0, 1 and 2, and code 3 is treated as 4. Both outputs hold their previous values until `done`.
- R3: `done` is a one-cycle pulse that is high right after the eleventh rising edge following the edge that sampled `load`. It goes low on the next edge.
- R4: `flag_low` is set when `nmult` is below 6, or below 7 when `single_out` is 1.
- R5: `flag_high` is set when `nmult` is above 64.
- R6: `flag_rate` is set when `nmult` exceeds twice `avail_cycles`. Equality does not set it.
- R7: `flag_line` is set when `nmult` exceeds the input delay-line size minus one. The line size is 64, 32 or 16 for `chan_sel` codes 0, 1 and 2 (1, 2 or 4 channels), and code 3 is treated as 2.
- R8: With `relax` high, the `flag_line` limit rises to the full line size, so `nmult` equal to the line size is legal.
- R9: After reset, `ndelay`, `taps`, `done` and all four flags are zero.
- R10: When `nmult` is zero, or the quotient in R2 is zero, `ndelay` and `taps` are zero.
- R11: A `load` during a computation abandons it. Only one `done` follows, carrying the newer settings, at the R3 timing counted from the newer `load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture settings and start derivation |
| nmult | input | 7 | Multiplies per output sample |
| filt_sel | input | 2 | Filter count code (0:1, 1:2, 2/3:4) |
| chan_sel | input | 2 | Channel count code (0:1, 1:2, 2/3:4) |
| nonsym | input | 1 | 1 for a non-symmetric filter |
| single_out | input | 1 | 1 when only one output is produced |
| avail_cycles | input | 12 | Clock cycles available per output |
| relax | input | 1 | Allow nmult equal to the delay-line size |
| ndelay | output | 10 | Derived delay count |
| taps | output | 17 | Derived total filter length |
| done | output | 1 | Pulse when ndelay and taps are valid |
| flag_low | output | 1 | nmult below minimum |
| flag_high | output | 1 | nmult above maximum |
| flag_rate | output | 1 | nmult beyond multiplier cycles |
| flag_line | output | 1 | nmult beyond delay-line size |

## Verification
The hardest case to reach is a restart: a second `load` arrives while the divider is part-way through its ten steps. The first result must then never appear, and `done` must line up with the second `load`. The bench issues one load, waits three cycles and issues another with different settings. It counts every `done` pulse in the window where the first result would have landed, then checks the geometry of the second set. The limit boundaries are also hard to hit, because each lies exactly at equality. Vectors place `nmult` at exactly twice the cycle budget and at exactly the line size, with and without `relax`.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

    typedef struct packed {
        logic line;
        logic rate;
        logic high;
        logic low;
    } viol_t;

    // Map a 2-bit count code to log2 of the count; code 3 saturates to 2.
    function automatic logic [1:0] sel_to_log2(input logic [1:0] sel);
        return (sel == 2'd3) ? 2'd2 : sel;
    endfunction

endpackage

// File: rtl/rcfg_limits.sv
module rcfg_limits
    import rcfg_pkg::*;
#(
    parameter int NMULT_W   = 7,
    parameter int CYC_W     = 12,
    parameter int NMULT_MIN = 6,
    parameter int NMULT_MAX = 64,
    parameter int LINE_MAX  = 64
) (
    input  logic [NMULT_W-1:0] nmult,
    input  logic [1:0]         chan_sel,
    input  logic               single_out,
    input  logic [CYC_W-1:0]   avail_cycles,
    input  logic               relax,
    output viol_t              viol
);

    logic [31:0] n32;
    logic [31:0] min_c;
    logic [31:0] line_c;
    logic [31:0] lim_c;
    logic [31:0] mult_budget;

    always_comb begin
        n32         = 32'(nmult);
        min_c       = single_out ? 32'(NMULT_MIN + 1) : 32'(NMULT_MIN);
        line_c      = 32'(LINE_MAX) >> sel_to_log2(chan_sel);
        lim_c       = relax ? line_c : line_c - 32'd1;
        mult_budget = 32'(avail_cycles) << 1;

        viol.low  = n32 < min_c;
        viol.high = n32 > 32'(NMULT_MAX);
        viol.rate = n32 > mult_budget;
        viol.line = n32 > lim_c;
    end

    // Guard: an nmult inside the legal window never reports both range errors.
    always_comb begin
        assert_range_exclusive_R5: assert (!(viol.low && viol.high));
    end

endmodule

// File: rtl/rcfg_divider.sv
module rcfg_divider #(
    parameter int QW = 10,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [QW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [QW-1:0] quot,
    output logic          valid
);

    localparam int CW = $clog2(QW + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [DW:0]   rem;
        logic [QW-1:0] dvd;
        logic [QW-1:0] quo;
        logic [DW-1:0] dsr;
        logic          valid;
    } div_t;

    div_t s_d, s_q;
    logic [DW:0] trial;
    logic        qbit;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        trial     = {s_q.rem[DW-1:0], s_q.dvd[QW-1]};
        qbit      = trial >= {1'b0, s_q.dsr};
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(QW);
            s_d.rem  = '0;
            s_d.dvd  = dividend;
            s_d.quo  = '0;
            s_d.dsr  = divisor;
        end else if (s_q.busy) begin
            s_d.rem = qbit ? (trial - {1'b0, s_q.dsr}) : trial;
            s_d.quo = {s_q.quo[QW-2:0], qbit};
            s_d.dvd = {s_q.dvd[QW-2:0], 1'b0};
            s_d.cnt = s_q.cnt - CW'(1);
            if (s_q.cnt == CW'(1)) begin
                s_d.busy  = 1'b0;
                s_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign quot  = s_q.quo;
    assign valid = s_q.valid;

    // R2: the finished quotient and remainder reconstruct the dividend exactly.
    assert_quot_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.valid && s_q.dsr != '0) |->
            (32'(s_q.rem) < 32'(s_q.dsr)) &&
            (32'(s_q.quo) * 32'(s_q.dsr) + 32'(s_q.rem) == 32'(dividend)));

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> !s_q.valid);

endmodule

// File: rtl/rcfg_pow2floor.sv
module rcfg_pow2floor #(
    parameter int W = 10
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] pow2
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (i == W - 1) begin : g_top
                assign pow2[i] = val[i];
            end else begin : g_low
                assign pow2[i] = val[i] & ~(|val[W-1:i+1]);
            end
        end
    endgenerate

    always_comb begin
        assert_pow2_onehot_R2: assert ($onehot0(pow2));
    end

endmodule

// File: rtl/rsmp_cfg_derive.sv
module rsmp_cfg_derive
    import rcfg_pkg::*;
#(
    parameter int NMULT_W   = 7,
    parameter int CYC_W     = 12,
    parameter int MEM_WORDS = 256,
    parameter int NMULT_MIN = 6,
    parameter int NMULT_MAX = 64,
    parameter int LINE_MAX  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [NMULT_W-1:0]         nmult,
    input  logic [1:0]                 filt_sel,
    input  logic [1:0]                 chan_sel,
    input  logic                       nonsym,
    input  logic                       single_out,
    input  logic [CYC_W-1:0]           avail_cycles,
    input  logic                       relax,
    output logic [$clog2(2*MEM_WORDS):0]         ndelay,
    output logic [NMULT_W+$clog2(2*MEM_WORDS):0] taps,
    output logic                       done,
    output logic                       flag_low,
    output logic                       flag_high,
    output logic                       flag_rate,
    output logic                       flag_line
);

    localparam int QW = $clog2(2 * MEM_WORDS) + 1;
    localparam int DW = NMULT_W + 3;
    localparam int TW = NMULT_W + QW;

    typedef struct packed {
        viol_t              viol;
        logic [NMULT_W-1:0] nmult;
        logic [QW-1:0]      ndelay;
        logic [TW-1:0]      taps;
        logic               done;
    } top_t;

    top_t  r_d, r_q;
    viol_t viol_c;
    logic [DW-1:0] divisor_c;
    logic [2:0]    shift_c;
    logic [QW-1:0] quot_w;
    logic [QW-1:0] floor_w;
    logic          div_valid;
    logic [QW-1:0] nd_c;

    rcfg_limits #(
        .NMULT_W   (NMULT_W),
        .CYC_W     (CYC_W),
        .NMULT_MIN (NMULT_MIN),
        .NMULT_MAX (NMULT_MAX),
        .LINE_MAX  (LINE_MAX)
    ) u_limits (
        .nmult        (nmult),
        .chan_sel     (chan_sel),
        .single_out   (single_out),
        .avail_cycles (avail_cycles),
        .relax        (relax),
        .viol         (viol_c)
    );

    always_comb begin
        shift_c   = {1'b0, sel_to_log2(filt_sel)} + {2'b0, nonsym};
        divisor_c = DW'(32'(nmult) << shift_c);
    end

    rcfg_divider #(
        .QW (QW),
        .DW (DW)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (load),
        .dividend (QW'(2 * MEM_WORDS)),
        .divisor  (divisor_c),
        .quot     (quot_w),
        .valid    (div_valid)
    );

    rcfg_pow2floor #(
        .W (QW)
    ) u_floor (
        .val  (quot_w),
        .pow2 (floor_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        nd_c     = (r_q.nmult == '0) ? '0 : floor_w;
        if (load) begin
            r_d.viol  = viol_c;
            r_d.nmult = nmult;
        end else if (div_valid) begin
            r_d.ndelay = nd_c;
            r_d.taps   = TW'(32'(nd_c) * 32'(r_q.nmult));
            r_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ndelay    = r_q.ndelay;
    assign taps      = r_q.taps;
    assign done      = r_q.done;
    assign flag_low  = r_q.viol.low;
    assign flag_high = r_q.viol.high;
    assign flag_rate = r_q.viol.rate;
    assign flag_line = r_q.viol.line;

    assert_flags_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(r_q.viol));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    assert_ndelay_pow2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_q.ndelay));

    assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !div_valid |=> $stable(r_q.ndelay) && $stable(r_q.taps));

    assert_zero_geometry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> ((r_q.ndelay == '0) == (r_q.taps == '0)));

endmodule

// File: tb/rsmp_cfg_derive_tb.sv
module rsmp_cfg_derive_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [6:0]  nmult = '0;
    logic [1:0]  filt_sel = '0;
    logic [1:0]  chan_sel = '0;
    logic        nonsym = 1'b0;
    logic        single_out = 1'b0;
    logic [11:0] avail_cycles = '0;
    logic        relax = 1'b0;
    logic [9:0]  ndelay;
    logic [16:0] taps;
    logic        done;
    logic        flag_low, flag_high, flag_rate, flag_line;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rsmp_cfg_derive u_dut (
        .clk (clk), .rst_n (rst_n), .load (load), .nmult (nmult),
        .filt_sel (filt_sel), .chan_sel (chan_sel), .nonsym (nonsym),
        .single_out (single_out), .avail_cycles (avail_cycles), .relax (relax),
        .ndelay (ndelay), .taps (taps), .done (done),
        .flag_low (flag_low), .flag_high (flag_high),
        .flag_rate (flag_rate), .flag_line (flag_line)
    );

    // flags packed {line, rate, high, low}
    typedef struct packed {
        logic [6:0]  nm;
        logic [1:0]  fs;
        logic [1:0]  cs;
        logic        ns;
        logic        so;
        logic [11:0] cy;
        logic        rx;
        logic [9:0]  exp_nd;
        logic [16:0] exp_taps;
        logic [3:0]  exp_fl;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{7'd15,  2'd0, 2'd2, 1'b0, 1'b0, 12'd100, 1'b0, 10'd32, 17'd480, 4'b0000},
        '{7'd6,   2'd0, 2'd0, 1'b0, 1'b1, 12'd100, 1'b0, 10'd64, 17'd384, 4'b0001},
        '{7'd64,  2'd2, 2'd0, 1'b1, 1'b0, 12'd100, 1'b0, 10'd1,  17'd64,  4'b1000},
        '{7'd64,  2'd2, 2'd0, 1'b1, 1'b0, 12'd100, 1'b1, 10'd1,  17'd64,  4'b0000},
        '{7'd20,  2'd1, 2'd1, 1'b0, 1'b0, 12'd9,   1'b0, 10'd8,  17'd160, 4'b0100},
        '{7'd100, 2'd0, 2'd0, 1'b0, 1'b0, 12'd100, 1'b0, 10'd4,  17'd400, 4'b1010},
        '{7'd16,  2'd1, 2'd2, 1'b1, 1'b0, 12'd8,   1'b1, 10'd8,  17'd128, 4'b0000},
        '{7'd16,  2'd1, 2'd2, 1'b1, 1'b0, 12'd8,   1'b0, 10'd8,  17'd128, 4'b1000},
        '{7'd17,  2'd0, 2'd0, 1'b0, 1'b0, 12'd8,   1'b0, 10'd16, 17'd272, 4'b0100},
        '{7'd7,   2'd0, 2'd0, 1'b0, 1'b1, 12'd100, 1'b0, 10'd64, 17'd448, 4'b0000},
        '{7'd0,   2'd0, 2'd0, 1'b0, 1'b0, 12'd100, 1'b0, 10'd0,  17'd0,   4'b0001},
        '{7'd127, 2'd3, 2'd3, 1'b1, 1'b0, 12'd100, 1'b0, 10'd0,  17'd0,   4'b1010},
        '{7'd6,   2'd0, 2'd0, 1'b0, 1'b0, 12'd3,   1'b0, 10'd64, 17'd384, 4'b0000},
        '{7'd7,   2'd0, 2'd0, 1'b0, 1'b0, 12'd3,   1'b0, 10'd64, 17'd448, 4'b0100}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] flags();
        return {flag_line, flag_rate, flag_high, flag_low};
    endfunction

    task automatic drive(input vec_t v);
        nmult = v.nm; filt_sel = v.fs; chan_sel = v.cs; nonsym = v.ns;
        single_out = v.so; avail_cycles = v.cy; relax = v.rx;
    endtask

    // Load at one edge, check flags right after it, done after edge 11.
    task automatic run_vec(input vec_t v);
        int seen;
        @(negedge clk);
        drive(v);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R1/R4/R5/R6/R7/R8 flags", 32'(flags()), 32'(v.exp_fl));
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk("R3 no early done", 32'(seen), 32'd0);
        @(negedge clk);
        chk("R3 done pulse", 32'(done), 32'd1);
        chk("R2/R10 ndelay", 32'(ndelay), 32'(v.exp_nd));
        chk("R2/R10 taps", 32'(taps), 32'(v.exp_taps));
        @(negedge clk);
        chk("R3 done falls", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset ndelay", 32'(ndelay), 32'd0);
        chk("R9 reset taps", 32'(taps), 32'd0);
        chk("R9 reset done/flags", 32'({done, flags()}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(TBL[i]);

        // R1: inputs change without load; flags and geometry stay put
        run_vec(TBL[5]);
        drive(TBL[0]);
        single_out = 1'b1;
        nmult = 7'd2;
        repeat (15) @(negedge clk);
        chk("R1 flags held", 32'(flags()), 32'b1010);
        chk("R1 ndelay held", 32'(ndelay), 32'd4);
        chk("R1 taps held", 32'(taps), 32'd400);

        // R11: second load three cycles into a computation
        begin
            int seen;
            @(negedge clk);
            drive(TBL[5]);
            load = 1'b1;
            @(negedge clk);
            load = 1'b0;
            repeat (2) @(negedge clk);
            drive(TBL[8]);
            load = 1'b1;
            @(negedge clk);
            load = 1'b0;
            chk("R11 flags of newer load", 32'(flags()), 32'(TBL[8].exp_fl));
            seen = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (done) seen++;
            end
            chk("R11 abandoned result never done", 32'(seen), 32'd0);
            @(negedge clk);
            chk("R11 single done", 32'(done), 32'd1);
            chk("R11 ndelay newer", 32'(ndelay), 32'(TBL[8].exp_nd));
            chk("R11 taps newer", 32'(taps), 32'(TBL[8].exp_taps));
            seen = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (done) seen++;
            end
            chk("R11 no extra done", 32'(seen), 32'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule